// File: doc/BRIEF.md
# Register-Pair ALU Execute Unit

This unit executes the register-to-register arithmetic, logic, shift and compare-and-skip instructions of a small 8-bit virtual machine. The machine has sixteen 8-bit general registers. The last of them, register 15, also serves as the flag register. A 16-bit instruction word arrives together with a one-cycle valid strobe. The unit decodes it, reads two registers, computes the result and a flag, and writes them back. It also advances a 12-bit program counter, all within the same clock edge.

An instruction that this unit does not define changes nothing in the machine state. Instead it raises a one-cycle illegal pulse. A debug port can load any register when no instruction is being executed. It can also read any register combinationally, so the surrounding machine or a test harness can preset and inspect the register file.

Top module: `alu_exec_unit`

## Requirements
- R1: A synchronous active-high reset clears all sixteen registers to 0x00, sets the program counter to 0x200 and drops the illegal pulse.
- R2: The instruction fields are: group = bits 15:12, x index = bits 11:8, y index = bits 7:4, operation = bits 3:0. In group 0x8, operation 0 copies Vy into Vx, 1 ORs Vy into Vx, 2 ANDs Vy into Vx and 3 XORs Vy into Vx. These four leave register 15 untouched unless x is 15.
- R3: Group 0x8, operation 4 sets Vx to (Vx + Vy) mod 256 and sets register 15 to 1 when the unsigned sum exceeds 255, otherwise to 0.
- R4: Group 0x8, operation 5 sets Vx to (Vx − Vy) mod 256 and sets register 15 to 1 only when Vx > Vy strictly, otherwise to 0.
- R5: Group 0x8, operation 7 sets Vx to (Vy − Vx) mod 256 and sets register 15 to 1 only when Vy > Vx strictly, otherwise to 0.
- R6: Group 0x8, operation 6 shifts Vx right by one and writes the old bit 0 of Vx into register 15 as the value 0 or 1.
- R7: Group 0x8, operation 0xE shifts Vx left by one and writes the old bit 7 of Vx into register 15 as the value 0 or 1.
- R8: Flags are computed from the operand values held before the instruction. When x is 15 for operations 4, 5, 6, 7 or 0xE, register 15 ends up holding the flag, not the result.
- R9: Every legal group 0x8 instruction advances the program counter by 2, modulo 4096.
- R10: Group 0x9 with operation 0 advances the program counter by 4 when Vx differs from Vy, and by 2 when they are equal. It writes no register.
- R11: Any other encoding is illegal. This covers group 0x8 with operation 8 to 0xD or 0xF, group 0x9 with a nonzero operation, and every other group. An illegal instruction leaves all registers and the program counter unchanged and raises the illegal pulse for exactly the one cycle after the edge that sampled it.
- R12: A debug write loads the data into the addressed register at the clock edge, but only when no valid instruction is present in that cycle. When a valid instruction is present, the debug write is ignored. The debug read port returns the addressed register combinationally.
- R13: In a cycle without a valid instruction or debug write, the registers and the program counter keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instrValid | input | 1 | Instruction word is present this cycle |
| instrWord | input | 16 | Instruction to execute |
| dbgWrEn | input | 1 | Debug register write enable |
| dbgWrAddr | input | 4 | Debug write register index |
| dbgWrData | input | 8 | Debug write data |
| dbgRdAddr | input | 4 | Debug read register index |
| dbgRdData | output | 8 | Addressed register contents (combinational) |
| pcOut | output | 12 | Program counter |
| illegalPulse | output | 1 | One-cycle pulse after an illegal instruction |

## Verification
Every result of an instruction is due exactly one clock edge after the cycle that presents it. This covers the written register, register 15, the program counter and the illegal pulse. The driver tags each expected item with that due cycle. The monitor pops the item only on the falling edge of that cycle and reads Vx and register 15 through the combinational debug read port. Because every expected pulse value is compared on the one falling edge where it is due, an illegal pulse that lasts into the following instruction's slot is caught. Debug-write and idle cases are checked by reading the register back through the debug port one edge later, before any further stimulus.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

  localparam int INSTR_W = 16;

  typedef enum logic [3:0] {
    ALU_COPY,
    ALU_OR,
    ALU_AND,
    ALU_XOR,
    ALU_ADD,
    ALU_SUB,
    ALU_SHR,
    ALU_SUBN,
    ALU_SHL
  } aluOp_t;

  typedef struct packed {
    aluOp_t aluOp;
    logic   instrActive;
    logic   wrResult;
    logic   wrFlag;
    logic   pcAdvance;
    logic   skipCmp;
    logic   illegal;
  } ctrlStrobes_t;

endpackage

// File: rtl/alu_exec_ctrl.sv
module alu_exec_ctrl
  import alu_exec_pkg::*;
#(
  parameter int NREG  = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                 instrValid,
  input  logic [INSTR_W-1:0]   instrWord,
  output logic [IDX_W-1:0]     xIdx,
  output logic [IDX_W-1:0]     yIdx,
  output ctrlStrobes_t         strobes
);

  localparam logic [3:0] GRP_ALU  = 4'h8;
  localparam logic [3:0] GRP_SKIP = 4'h9;

  logic [3:0] grpField;
  logic [3:0] opField;

  assign grpField = instrWord[15:12];
  assign opField  = instrWord[3:0];
  assign xIdx     = instrWord[8 +: IDX_W];
  assign yIdx     = instrWord[4 +: IDX_W];

  always_comb begin
    strobes             = '0;
    strobes.aluOp       = ALU_COPY;
    strobes.instrActive = instrValid;
    if (instrValid) begin
      unique case (grpField)
        GRP_ALU: begin
          strobes.pcAdvance = 1'b1;
          strobes.wrResult  = 1'b1;
          unique case (opField)
            4'h0: strobes.aluOp = ALU_COPY;
            4'h1: strobes.aluOp = ALU_OR;
            4'h2: strobes.aluOp = ALU_AND;
            4'h3: strobes.aluOp = ALU_XOR;
            4'h4: begin strobes.aluOp = ALU_ADD;  strobes.wrFlag = 1'b1; end
            4'h5: begin strobes.aluOp = ALU_SUB;  strobes.wrFlag = 1'b1; end
            4'h6: begin strobes.aluOp = ALU_SHR;  strobes.wrFlag = 1'b1; end
            4'h7: begin strobes.aluOp = ALU_SUBN; strobes.wrFlag = 1'b1; end
            4'hE: begin strobes.aluOp = ALU_SHL;  strobes.wrFlag = 1'b1; end
            default: begin
              strobes.pcAdvance = 1'b0;
              strobes.wrResult  = 1'b0;
              strobes.illegal   = 1'b1;
            end
          endcase
        end
        GRP_SKIP: begin
          if (opField == 4'h0) strobes.skipCmp = 1'b1;
          else                 strobes.illegal = 1'b1;
        end
        default: strobes.illegal = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/alu_exec_alu.sv
module alu_exec_alu
  import alu_exec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluOp_t              op,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  output logic [DATA_W-1:0]   result,
  output logic                flagBit
);

  logic [DATA_W:0] sumWide;

  assign sumWide = {1'b0, opA} + {1'b0, opB};

  always_comb begin
    result  = opB;
    flagBit = 1'b0;
    unique case (op)
      ALU_COPY: result = opB;
      ALU_OR:   result = opA | opB;
      ALU_AND:  result = opA & opB;
      ALU_XOR:  result = opA ^ opB;
      ALU_ADD: begin
        result  = sumWide[DATA_W-1:0];
        flagBit = sumWide[DATA_W];
      end
      ALU_SUB: begin
        result  = opA - opB;
        flagBit = opA > opB;
      end
      ALU_SUBN: begin
        result  = opB - opA;
        flagBit = opB > opA;
      end
      ALU_SHR: begin
        result  = opA >> 1;
        flagBit = opA[0];
      end
      ALU_SHL: begin
        result  = opA << 1;
        flagBit = opA[DATA_W-1];
      end
      default: begin
        result  = opB;
        flagBit = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu_exec_dp.sv
module alu_exec_dp
  import alu_exec_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                NREG     = 16,
  parameter int                PC_W     = 12,
  parameter logic [PC_W-1:0]   PC_RESET = 12'h200,
  localparam int               IDX_W    = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobes_t       strobes,
  input  logic [IDX_W-1:0]   xIdx,
  input  logic [IDX_W-1:0]   yIdx,
  input  logic               dbgWrEn,
  input  logic [IDX_W-1:0]   dbgWrAddr,
  input  logic [DATA_W-1:0]  dbgWrData,
  input  logic [IDX_W-1:0]   dbgRdAddr,
  output logic [DATA_W-1:0]  dbgRdData,
  output logic [PC_W-1:0]    pcOut,
  output logic               illegalPulse
);

  localparam int FLAG_IDX = NREG - 1;
  localparam logic [PC_W-1:0] STEP_ONE = PC_W'(2);
  localparam logic [PC_W-1:0] STEP_TWO = PC_W'(4);

  logic [NREG-1:0][DATA_W-1:0] regBank;
  logic [DATA_W-1:0]           vxVal;
  logic [DATA_W-1:0]           vyVal;
  logic [DATA_W-1:0]           aluResult;
  logic                        aluFlag;
  logic [DATA_W-1:0]           flagWord;
  logic                        dbgAllowed;
  logic [PC_W-1:0]             pcQ;
  logic                        illegalQ;

  assign vxVal      = regBank[xIdx];
  assign vyVal      = regBank[yIdx];
  assign flagWord   = DATA_W'(aluFlag);
  assign dbgAllowed = dbgWrEn && !strobes.instrActive;
  assign dbgRdData  = regBank[dbgRdAddr];

  alu_exec_alu #(.DATA_W(DATA_W)) u_alu (
    .op      (strobes.aluOp),
    .opA     (vxVal),
    .opB     (vyVal),
    .result  (aluResult),
    .flagBit (aluFlag)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic resultWe;
    logic flagWe;
    logic dbgWe;

    assign resultWe = strobes.wrResult && (xIdx == IDX_W'(g));
    assign flagWe   = strobes.wrFlag && (g == FLAG_IDX);
    assign dbgWe    = dbgAllowed && (dbgWrAddr == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst)           regBank[g] <= '0;
      else if (flagWe)   regBank[g] <= flagWord;
      else if (resultWe) regBank[g] <= aluResult;
      else if (dbgWe)    regBank[g] <= dbgWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ      <= PC_RESET;
      illegalQ <= 1'b0;
    end else begin
      illegalQ <= strobes.illegal;
      if (strobes.skipCmp)
        pcQ <= pcQ + ((vxVal != vyVal) ? STEP_TWO : STEP_ONE);
      else if (strobes.pcAdvance)
        pcQ <= pcQ + STEP_ONE;
    end
  end

  assign pcOut        = pcQ;
  assign illegalPulse = illegalQ;

endmodule

// File: rtl/alu_exec_unit.sv
module alu_exec_unit
  import alu_exec_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                NREG     = 16,
  parameter int                PC_W     = 12,
  parameter logic [PC_W-1:0]   PC_RESET = 12'h200,
  localparam int               IDX_W    = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instrValid,
  input  logic [15:0]        instrWord,
  input  logic               dbgWrEn,
  input  logic [IDX_W-1:0]   dbgWrAddr,
  input  logic [DATA_W-1:0]  dbgWrData,
  input  logic [IDX_W-1:0]   dbgRdAddr,
  output logic [DATA_W-1:0]  dbgRdData,
  output logic [PC_W-1:0]    pcOut,
  output logic               illegalPulse
);

  ctrlStrobes_t     strobes;
  logic [IDX_W-1:0] xIdx;
  logic [IDX_W-1:0] yIdx;

  alu_exec_ctrl #(.NREG(NREG)) u_ctrl (
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .xIdx       (xIdx),
    .yIdx       (yIdx),
    .strobes    (strobes)
  );

  alu_exec_dp #(
    .DATA_W   (DATA_W),
    .NREG     (NREG),
    .PC_W     (PC_W),
    .PC_RESET (PC_RESET)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strobes      (strobes),
    .xIdx         (xIdx),
    .yIdx         (yIdx),
    .dbgWrEn      (dbgWrEn),
    .dbgWrAddr    (dbgWrAddr),
    .dbgWrData    (dbgWrData),
    .dbgRdAddr    (dbgRdAddr),
    .dbgRdData    (dbgRdData),
    .pcOut        (pcOut),
    .illegalPulse (illegalPulse)
  );

endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk #(
  parameter int              PC_W     = 12,
  parameter logic [PC_W-1:0] PC_RESET = 12'h200
) (
  input logic            clk,
  input logic            rst,
  input logic            instrValid,
  input logic [PC_W-1:0] pcOut,
  input logic            illegalPulse
);

  // R1: the first edge after reset shows the start address and no pulse
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pcOut == PC_RESET && !illegalPulse));

  // R11: a pulse only follows a cycle that carried an instruction
  a_r11_pulse_has_cause: assert property (@(posedge clk) disable iff (rst)
    illegalPulse |-> $past(instrValid));

  // R11: an illegal instruction leaves the program counter alone
  a_r11_pc_frozen: assert property (@(posedge clk) disable iff (rst)
    illegalPulse |-> $stable(pcOut));

  // R9 and R10: the counter only stays, steps by 2 or steps by 4
  a_r10_pc_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pcOut == $past(pcOut) ||
                     pcOut == $past(pcOut) + PC_W'(2) ||
                     pcOut == $past(pcOut) + PC_W'(4)));

  // R13: no instruction, no movement of the counter
  a_r13_idle_pc: assert property (@(posedge clk) disable iff (rst)
    (!$past(instrValid) && !$past(rst)) |-> $stable(pcOut));

endmodule

bind alu_exec_unit alu_exec_chk #(.PC_W(PC_W), .PC_RESET(PC_RESET)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .instrValid   (instrValid),
  .pcOut        (pcOut),
  .illegalPulse (illegalPulse)
);

// File: tb/alu_exec_unit_tb.sv
module alu_exec_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instrValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic        dbgWrEn = 1'b0;
  logic [3:0]  dbgWrAddr = '0;
  logic [7:0]  dbgWrData = '0;
  logic [3:0]  dbgRdAddr = '0;
  logic [7:0]  dbgRdData;
  logic [11:0] pcOut;
  logic        illegalPulse;

  alu_exec_unit u_dut (
    .clk(clk), .rst(rst), .instrValid(instrValid), .instrWord(instrWord),
    .dbgWrEn(dbgWrEn), .dbgWrAddr(dbgWrAddr), .dbgWrData(dbgWrData),
    .dbgRdAddr(dbgRdAddr), .dbgRdData(dbgRdData),
    .pcOut(pcOut), .illegalPulse(illegalPulse)
  );

  always #5 clk = ~clk;

  typedef struct {
    int        due;
    logic [11:0] pc;
    logic      ill;
    logic [3:0] xi;
    logic [7:0] xv;
    logic [7:0] fv;
    string     tag;
  } expItem_t;

  expItem_t    sbQueue[$];
  int          cyc = 0;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;
  logic [7:0]  mdl [16];
  logic [11:0] mpc;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops each expected item on the falling edge it is due
  always @(negedge clk) begin
    if (sbQueue.size() > 0 && sbQueue[0].due == cyc) begin
      expItem_t it;
      it = sbQueue.pop_front();
      chk(pcOut == it.pc, {it.tag, " pc"}, pcOut, it.pc);
      chk(illegalPulse == it.ill, {it.tag, " illegal"}, illegalPulse, it.ill);
      dbgRdAddr = it.xi;
      #1;
      chk(dbgRdData == it.xv, {it.tag, " Vx"}, dbgRdData, it.xv);
      dbgRdAddr = 4'hF;
      #1;
      chk(dbgRdData == it.fv, {it.tag, " VF"}, dbgRdData, it.fv);
    end
  end

  // driver: models the instruction from the requirements and queues the result
  task automatic run(input logic [15:0] w, input string tag);
    logic [3:0] grp, x, y, op;
    logic [7:0] vx, vy, res, flg;
    logic [8:0] sum;
    bit legal, wrF;
    expItem_t it;
    grp = w[15:12]; x = w[11:8]; y = w[7:4]; op = w[3:0];
    vx = mdl[x]; vy = mdl[y];
    legal = 1'b1; wrF = 1'b1; res = vy; flg = 8'h00;
    if (grp == 4'h8) begin
      case (op)
        4'h0: begin res = vy;      wrF = 1'b0; end
        4'h1: begin res = vx | vy; wrF = 1'b0; end
        4'h2: begin res = vx & vy; wrF = 1'b0; end
        4'h3: begin res = vx ^ vy; wrF = 1'b0; end
        4'h4: begin sum = {1'b0, vx} + {1'b0, vy}; res = sum[7:0]; flg = {7'd0, sum > 9'd255}; end
        4'h5: begin res = vx - vy; flg = {7'd0, vx > vy}; end
        4'h6: begin res = {1'b0, vx[7:1]}; flg = {7'd0, vx[0]}; end
        4'h7: begin res = vy - vx; flg = {7'd0, vy > vx}; end
        4'hE: begin res = {vx[6:0], 1'b0}; flg = {7'd0, vx[7]}; end
        default: legal = 1'b0;
      endcase
      if (legal) begin
        mdl[x] = res;
        if (wrF) mdl[15] = flg;
        mpc = mpc + 12'd2;
      end
    end else if (grp == 4'h9 && op == 4'h0) begin
      mpc = mpc + ((vx != vy) ? 12'd4 : 12'd2);
    end else begin
      legal = 1'b0;
    end
    it.due = cyc + 1; it.pc = mpc; it.ill = !legal;
    it.xi = x; it.xv = mdl[x]; it.fv = mdl[15]; it.tag = tag;
    sbQueue.push_back(it);
    instrValid = 1'b1;
    instrWord  = w;
    @(negedge clk);
    instrValid = 1'b0;
    instrWord  = '0;
  endtask

  task automatic load(input logic [3:0] idx, input logic [7:0] val);
    dbgWrEn = 1'b1; dbgWrAddr = idx; dbgWrData = val;
    mdl[idx] = val;
    @(negedge clk);
    dbgWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [3:0] idx, input logic [7:0] exp, input string tag);
    dbgRdAddr = idx;
    #1;
    chk(dbgRdData == exp, tag, dbgRdData, exp);
  endtask

  task automatic drain();
    while (sbQueue.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    mpc = 12'h200;
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    chk(pcOut == 12'h200, "R1 pc", pcOut, 12'h200);
    chk(illegalPulse == 1'b0, "R1 illegal", illegalPulse, 0);
    for (int i = 0; i < 16; i++) readReg(4'(i), 8'h00, "R1 reg clear");
    rst = 1'b0;
    @(negedge clk);

    // R12: debug loads and reads
    load(4'h1, 8'h3C); load(4'h2, 8'hA5); load(4'h3, 8'hF0); load(4'h4, 8'h0F);
    load(4'h5, 8'hFF); load(4'h6, 8'h01); load(4'h7, 8'h40); load(4'h8, 8'h40);
    load(4'h9, 8'h81); load(4'hA, 8'h10);
    readReg(4'h2, 8'hA5, "R12 debug load");

    // R2: copy and bitwise
    run(16'h8120, "R2 copy");
    run(16'h8231, "R2 or");
    run(16'h8342, "R2 and");
    run(16'h8413, "R2 xor");
    // R3: add without and with carry
    run(16'h8A74, "R3 add no carry");
    run(16'h8564, "R3 add carry");
    // R4: subtract equal, greater, less
    run(16'h8785, "R4 sub equal");
    load(4'h7, 8'h40);
    run(16'h8765, "R4 sub greater");
    run(16'h86A5, "R4 sub less");
    // R5: reverse subtract
    run(16'h8A17, "R5 subn greater");
    run(16'h8B07, "R5 subn equal");
    // R6: right shift odd and even
    run(16'h8906, "R6 shr odd");
    run(16'h8906, "R6 shr even");
    // R7: left shift with top bit set and clear
    load(4'hC, 8'h81);
    run(16'h8C0E, "R7 shl top set");
    run(16'h8C0E, "R7 shl top clear");
    // R8: destination is the flag register
    load(4'hF, 8'h80);
    run(16'h8F0E, "R8 shl on flag reg");
    load(4'hF, 8'hF0);
    run(16'h8F54, "R8 add on flag reg");
    load(4'hF, 8'h03);
    run(16'h8F06, "R8 shr on flag reg");
    load(4'hF, 8'h55);
    run(16'h8F21, "R2 or on flag reg");
    // R9 is covered by every pc check above; R10: skip differ and equal
    load(4'h7, 8'h40); load(4'h8, 8'h40);
    run(16'h9120, "R10 skip differ");
    run(16'h9780, "R10 skip equal");
    run(16'h9330, "R10 skip same reg");
    // R11: illegal encodings, one back to back with legal
    run(16'h8128, "R11 group8 op8");
    run(16'h812F, "R11 group8 opF");
    run(16'h812D, "R11 group8 opD");
    run(16'h9121, "R11 skip nonzero op");
    run(16'h0123, "R11 group0");
    run(16'hF000, "R11 groupF");
    run(16'h8230, "R9 legal after illegal");
    drain();
    chk(illegalPulse == 1'b0, "R11 pulse dropped", illegalPulse, 0);

    // R12: debug write ignored while an instruction is valid
    dbgWrEn = 1'b1; dbgWrAddr = 4'hD; dbgWrData = 8'hAA;
    run(16'h8340, "R12 instr with debug write");
    dbgWrEn = 1'b0;
    drain();
    readReg(4'hD, mdl[13], "R12 debug ignored");

    // R13: idle cycles keep state
    repeat (3) @(negedge clk);
    chk(pcOut == mpc, "R13 idle pc", pcOut, mpc);
    readReg(4'h3, mdl[3], "R13 idle reg");
    chk(illegalPulse == 1'b0, "R13 idle illegal", illegalPulse, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule